// File: doc/BRIEF.md
# Signed Nibble Seven-Segment Decoder

This block turns a 4-bit two's complement number into the segment drive for a pair of seven-segment digits. Read together, the two digits give the signed decimal value, anywhere from -8 up to +7. The left digit is used only as a minus sign. The right digit shows the absolute value as a single decimal numeral, from 0 to 8.

The decoder has no clock and no state. The data nibble goes in, and both segment buses follow after gate delay only. The block is meant to sit right in front of a pair of static, active-high seven-segment displays. On each bus, bit 0 drives segment a, and the bits then run upward through b, c, d, e and f to segment g in bit 6. A 1 lights the segment.

Top module: `signed_nibble_display`

## Requirements
- R1: Segments a through f of the sign digit (`sign_seg[5:0]`) are 0 for all sixteen input codes.
- R2: The sign digit's middle bar (`sign_seg[6]`, segment g) is 1 exactly when input bit 3 is 1, so it lights for negative values only.
- R3: The magnitude digit shows the absolute value of the input using these {g,f,e,d,c,b,a} codes: 0=7'h3F, 1=7'h06, 2=7'h5B, 3=7'h4F, 4=7'h66, 5=7'h6D, 6=7'h7D, 7=7'h07, 8=7'h7F.
- R4: Input 4'b1000 (-8) gives `sign_seg`=7'h40 and `mag_seg`=7'h7F. The magnitude 8 is formed as an unsigned value and does not wrap.
- R5: Input 4'b0000 gives `sign_seg`=7'h00 and `mag_seg`=7'h3F. Zero never carries a minus sign.
- R6: For non-negative inputs (bit 3 = 0), the magnitude digit shows the input value itself. Example: 4'b0011 gives `mag_seg`=7'h4F and `sign_seg`=7'h00.
- R7: For negative inputs, the magnitude digit shows the two's complement negation of the input, read as a 4-bit unsigned number. Example: 4'b1111 (-1) gives `mag_seg`=7'h06.
- R8: Both outputs are a pure function of the current input. A change on `data_in` appears on both buses with no clock edge and is not affected by earlier inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | 4 | Two's complement value, bit 3 is the most significant bit |
| sign_seg | output | 7 | Sign digit segments {g,f,e,d,c,b,a}, active high |
| mag_seg | output | 7 | Magnitude digit segments {g,f,e,d,c,b,a}, active high |

## Verification
The hardest case to reach is the most negative code, 4'b1000. It is the only code whose negation overflows a signed nibble, and it is the only code that needs the glyph "8". A random draw hits it on only about one input in sixteen, so the stimulus applies it directly, and also next to its neighbours 4'b0111 and 4'b1001. A full directed sweep of all sixteen codes, run in both ascending and descending order, shows that each output depends only on the present input. Seeded random codes are then compared against a bench reference that computes the absolute value with integer arithmetic.

// File: rtl/snd_pkg.sv
package snd_pkg;
  localparam int unsigned NIB_W = 4;
  localparam int unsigned SEG_N = 7;
  localparam int unsigned SEG_G = 6;

  typedef logic [NIB_W-1:0] nib_t;
  typedef logic [SEG_N-1:0] seg_t;

  localparam seg_t SEG_DARK  = '0;
  localparam seg_t SEG_MINUS = seg_t'(1) << SEG_G;
endpackage

// File: rtl/snd_abs_unit.sv
module snd_abs_unit
  import snd_pkg::*;
(
  input  nib_t value_i,
  output logic neg_o,
  output nib_t abs_o
);
  always_comb begin
    neg_o = value_i[NIB_W-1];
    if (neg_o) abs_o = nib_t'(~value_i) + nib_t'(1);
    else       abs_o = value_i;
  end
endmodule

// File: rtl/snd_glyph_enc.sv
module snd_glyph_enc
  import snd_pkg::*;
(
  input  nib_t digit_i,
  output seg_t seg_o
);
  always_comb begin
    unique case (digit_i)
      4'd0:    seg_o = 7'h3F;
      4'd1:    seg_o = 7'h06;
      4'd2:    seg_o = 7'h5B;
      4'd3:    seg_o = 7'h4F;
      4'd4:    seg_o = 7'h66;
      4'd5:    seg_o = 7'h6D;
      4'd6:    seg_o = 7'h7D;
      4'd7:    seg_o = 7'h07;
      4'd8:    seg_o = 7'h7F;
      4'd9:    seg_o = 7'h6F;
      default: seg_o = SEG_DARK;
    endcase
  end
endmodule

// File: rtl/snd_sign_drv.sv
module snd_sign_drv
  import snd_pkg::*;
(
  input  logic neg_i,
  output seg_t seg_o
);
  always_comb begin
    seg_o = neg_i ? SEG_MINUS : SEG_DARK;
  end
endmodule

// File: rtl/signed_nibble_display.sv
module signed_nibble_display
  import snd_pkg::*;
(
  input  logic [3:0] data_in,
  output logic [6:0] sign_seg,
  output logic [6:0] mag_seg
);
  logic neg_w;
  nib_t abs_w;

  snd_abs_unit u_abs (
    .value_i (data_in),
    .neg_o   (neg_w),
    .abs_o   (abs_w)
  );

  snd_glyph_enc u_glyph (
    .digit_i (abs_w),
    .seg_o   (mag_seg)
  );

  snd_sign_drv u_sign (
    .neg_i (neg_w),
    .seg_o (sign_seg)
  );
endmodule

// File: rtl/signed_nibble_display_chk.sv
module signed_nibble_display_chk (
  input logic [3:0] data_in,
  input logic [6:0] sign_seg,
  input logic [6:0] mag_seg
);
  always_comb begin
    if (!$isunknown(data_in)) begin
      assert_sign_upper_dark_R1: assert (sign_seg[5:0] == 6'd0)
        else $error("sign digit a-f lit");
      assert_minus_tracks_msb_R2: assert (sign_seg[6] == data_in[3])
        else $error("minus bar mismatch");
      assert_glyph_nonblank_R3: assert (mag_seg != 7'd0)
        else $error("magnitude digit blank");
      if (data_in == 4'b1000) begin
        assert_min_value_R4: assert (mag_seg == 7'h7F && sign_seg == 7'h40)
          else $error("-8 rendered wrongly");
      end
      if (data_in == 4'b0000) begin
        assert_zero_unsigned_R5: assert (mag_seg == 7'h3F && sign_seg == 7'h00)
          else $error("zero rendered wrongly");
      end
      if (!data_in[3]) begin
        assert_positive_no_eight_R6: assert (mag_seg != 7'h7F)
          else $error("non-negative input shows 8");
      end
    end
  end
endmodule

bind signed_nibble_display signed_nibble_display_chk u_chk (
  .data_in  (data_in),
  .sign_seg (sign_seg),
  .mag_seg  (mag_seg)
);

// File: tb/sim_signed_nibble_display.sv
module sim_signed_nibble_display;
  logic       clk;
  logic [3:0] data_in;
  logic [6:0] sign_seg;
  logic [6:0] mag_seg;
  int         n_run;
  int         n_fail;
  int         cyc;

  signed_nibble_display u0 (
    .data_in  (data_in),
    .sign_seg (sign_seg),
    .mag_seg  (mag_seg)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [6:0] ref_glyph(input int d);
    case (d)
      0: return 7'h3F;
      1: return 7'h06;
      2: return 7'h5B;
      3: return 7'h4F;
      4: return 7'h66;
      5: return 7'h6D;
      6: return 7'h7D;
      7: return 7'h07;
      8: return 7'h7F;
      default: return 7'h00;
    endcase
  endfunction

  function automatic int ref_value(input logic [3:0] v);
    return v[3] ? int'(v) - 16 : int'(v);
  endfunction

  function automatic logic [6:0] ref_mag(input logic [3:0] v);
    int s;
    s = ref_value(v);
    return ref_glyph(s < 0 ? -s : s);
  endfunction

  function automatic logic [6:0] ref_sign(input logic [3:0] v);
    return (ref_value(v) < 0) ? 7'h40 : 7'h00;
  endfunction

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s in=%b actual=%h expected=%h", req, data_in, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] v);
    @(posedge clk);
    data_in = v;
    @(negedge clk);
    check("R1", {1'b0, sign_seg[5:0]}, 7'h00);
    check("R2", {6'd0, sign_seg[6]}, {6'd0, v[3]});
    check(v[3] ? "R7" : "R6", mag_seg, ref_mag(v));
    check("R3", mag_seg, ref_mag(v));
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    n_run = 0;
    n_fail = 0;
    cyc = 0;
    seed = 32'd1234;
    data_in = 4'b0000;
    @(negedge clk);
    // R5: zero, no minus
    check("R5", sign_seg, 7'h00);
    check("R5", mag_seg, 7'h3F);
    // R4: most negative code and its neighbours
    apply(4'b0111);
    apply(4'b1000);
    check("R4", sign_seg, 7'h40);
    check("R4", mag_seg, 7'h7F);
    apply(4'b1001);
    // R6: +3 example
    apply(4'b0011);
    check("R6", mag_seg, 7'h4F);
    check("R6", sign_seg, 7'h00);
    // R7: -1
    apply(4'b1111);
    check("R7", mag_seg, 7'h06);
    // R8: ascending and descending sweeps, combinational response
    for (int i = 0; i < 16; i++) apply(4'(i));
    for (int i = 15; i >= 0; i--) apply(4'(i));
    data_in = 4'b1000;
    #1;
    check("R8", mag_seg, 7'h7F);
    data_in = 4'b0000;
    #1;
    check("R8", mag_seg, 7'h3F);
    check("R8", sign_seg, 7'h00);
    // random codes
    for (int k = 0; k < 200; k++) apply(4'($urandom(seed) & 32'hF) ^ 4'(k));
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule